// File: doc/BRIEF.md
# SDRAM Read/Write Access Sequencer

This block converts one burst request at a time into the command sequence a single-data-rate SDRAM with several banks expects. A requester presents a bank, a row, a starting column, a direction and an auto-close flag. The block opens the row, issues the column command once the row-to-column delay has elapsed, moves the burst, and closes the row again. It then waits out the recovery and precharge times before it takes the next request. Timing values, CAS latency and burst length are runtime configuration inputs. They must stay stable while a request is in progress.

Write data is streamed. For each beat the block raises `wr_take`, and the requester drives that beat's data and byte mask combinationally in the same cycle. Read data comes back one word per cycle on `rd_data`, qualified by `rd_valid`. Bytes that the request's read mask covers come back as zero.

The byte-mask pins follow two timings. On writes they act in the cycle they are driven. On reads they are driven two cycles ahead of the data they suppress. Between requests the block sits idle with `req_ready` high and drives NOP, so an external refresh engine can take over the command bus.

Top module: `sdram_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. In the following cycle the block drives Activate, with `sd_ba` equal to the request bank and `sd_addr` equal to the request row.
- R2: The column command (Read or Write) is driven exactly `cfg_trcd` cycles after the Activate cycle. `cfg_trcd`, `cfg_twr` and `cfg_trp` must lie in 2..15. The column command carries the start column on `sd_addr[COL_W-1:0]`.
- R3: Burst length is coded by `cfg_bl`: 00 gives 2 words, 01 gives 4 words, 10 and 11 give 8 words. A write drives `sd_dq_oe`, raises `wr_take` and places `wr_data` on `sd_dq_out` in that many consecutive cycles, starting in the cycle of the Write command. Outside those cycles `sd_dq_oe` and `wr_take` are low.
- R4: In every write beat, `sd_dqm` equals `wr_mask` of that same cycle. Bit b of the mask covers data bits 8b+7..8b, and a set bit keeps that byte of the stored word unchanged.
- R5: After a Read, the first word on `sd_dq_in` is taken CL cycles after the Read cycle, with CL = 3 when `cfg_cl3` is 1 and 2 otherwise. One word is taken per cycle for the burst length. Each word appears on `rd_data` with `rd_valid` high one cycle after it was on `sd_dq_in`.
- R6: During a read, `sd_dqm` equals the request's `req_rmask` from cycle Read+CL-2 through two cycles before the last data word, and is zero in the other cycles of that request. Bytes selected by `req_rmask` read as zero on `rd_data`.
- R7: A write without auto-close drives Precharge exactly `cfg_twr` cycles after its last data beat. A read drives Precharge in the cycle after its last data word. Precharge carries `sd_addr[10]` = 0 and the request bank.
- R8: A write with `req_auto` set drives `sd_addr[10]` = 1 on its Write command and never drives Precharge. `req_ready` returns `cfg_twr` + `cfg_trp` cycles after its last data beat.
- R9: After a Precharge, `req_ready` stays low for `cfg_trp` - 1 cycles and is high in the `cfg_trp`-th cycle.
- R10: `req_auto` has no effect on reads. The Read command carries `sd_addr[10]` = 0, and an explicit Precharge follows.
- R11: Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as NOP 0111, Activate 0011, Read 0101, Write 0100, Precharge 0010. Every cycle without another scheduled command is a NOP. Under reset the block drives NOP, `req_ready` 1, and `sd_dq_oe`, `sd_dqm` and `rd_valid` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cl3 | input | 1 | CAS latency select: 1 gives 3, 0 gives 2 |
| cfg_bl | input | 2 | Burst length code |
| cfg_trcd | input | CNT_W | Activate-to-column delay in cycles |
| cfg_twr | input | CNT_W | Write recovery in cycles |
| cfg_trp | input | CNT_W | Precharge time in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, a request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_auto | input | 1 | Close the row automatically after a write |
| req_bank | input | BANK_W | Bank |
| req_row | input | ADDR_W | Row |
| req_col | input | COL_W | Starting column |
| req_rmask | input | DQ_W/8 | Byte mask applied to every read word |
| wr_take | output | 1 | Current cycle is a write beat |
| wr_data | input | DQ_W | Write beat data |
| wr_mask | input | DQ_W/8 | Write beat byte mask |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DQ_W | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row / column address, bit 10 selects auto-close |
| sd_dqm | output | DQ_W/8 | Byte mask pins |
| sd_dq_out | output | DQ_W | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DQ_W | Data from the device |

## Verification
The bench builds the block with its defaults: a 16-bit data bus, so two mask lanes can differ within one word; four banks; 12 address bits; 8 column bits; and 4-bit timing counters. Within that build, the timing inputs are varied per request over 2..5 cycles, together with both CAS latencies and every burst code. This exercises the shortest tRCD and tWR waits and a read mask window that opens in the Read cycle itself (CL 2). It also covers a window that ends before an 8-word burst does, and burst wrap on unaligned columns against a device model that honours the two mask timings.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM access sequencer.
// Assumes one command per cycle on a single-data-rate device bus.
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE, CMD_PRE
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACT, ST_RCD, ST_XFER, ST_REC, ST_PRE, ST_RP
    } state_e;

    // Words per burst from the 2-bit length code.
    function automatic logic [3:0] burst_words(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // Active-low {cs, ras, cas, we} for a command.
    function automatic logic [3:0] cmd_pins(input cmd_e c);
        case (c)
            CMD_ACT:   return 4'b0011;
            CMD_READ:  return 4'b0101;
            CMD_WRITE: return 4'b0100;
            CMD_PRE:   return 4'b0010;
            default:   return 4'b0111;
        endcase
    endfunction

endpackage

// File: rtl/sdram_seq_ctrl.sv
// Sequencing state machine: open, transfer, recover, close, wait.
// Assumes timing inputs in 2..2**CNT_W-1, held stable while busy.
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cl3,
    input  logic [1:0]       cfg_bl,
    input  logic [CNT_W-1:0] cfg_trcd,
    input  logic [CNT_W-1:0] cfg_twr,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_auto,
    output logic             req_ready,
    output logic             accept,
    output cmd_e             cmd,
    output logic             auto_q,
    output logic             wbeat,
    output logic             rmask_win,
    output logic             rcapture
);
    state_e           state;
    logic [CNT_W-1:0] cnt;
    logic [CYC_W-1:0] cyc;
    logic             write_q;
    logic [CYC_W-1:0] cl;
    logic [CYC_W-1:0] bl;
    logic             in_xfer;

    assign cl        = cfg_cl3 ? CYC_W'(3) : CYC_W'(2);
    assign bl        = CYC_W'(burst_words(cfg_bl));
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign in_xfer   = (state == ST_XFER);

    // State and wait-counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cyc     <= '0;
            write_q <= 1'b0;
            auto_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state   <= ST_ACT;
                    write_q <= req_write;
                    auto_q  <= req_write && req_auto;
                end
                ST_ACT: begin
                    state <= ST_RCD;
                    cnt   <= cfg_trcd - CNT_W'(2);
                end
                ST_RCD: if (cnt == '0) begin
                    state <= ST_XFER;
                    cyc   <= '0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                ST_XFER: begin
                    cyc <= cyc + CYC_W'(1);
                    if (write_q && cyc == bl - CYC_W'(1)) begin
                        state <= ST_REC;
                        cnt   <= cfg_twr - CNT_W'(2);
                    end else if (!write_q && cyc == cl + bl - CYC_W'(1)) begin
                        state <= ST_PRE;
                    end
                end
                ST_REC: if (cnt == '0) state <= ST_PRE;
                        else           cnt   <= cnt - CNT_W'(1);
                ST_PRE: begin
                    state <= ST_RP;
                    cnt   <= cfg_trp - CNT_W'(2);
                end
                ST_RP: if (cnt == '0) state <= ST_IDLE;
                       else           cnt   <= cnt - CNT_W'(1);
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command decode from the current state.
    always_comb begin
        cmd = CMD_NOP;
        case (state)
            ST_ACT:  cmd = CMD_ACT;
            ST_XFER: if (cyc == '0) cmd = write_q ? CMD_WRITE : CMD_READ;
            ST_PRE:  if (!auto_q) cmd = CMD_PRE;
            default: cmd = CMD_NOP;
        endcase
    end

    // Data-phase windows relative to the column command.
    assign wbeat     = in_xfer && write_q && (cyc < bl);
    assign rmask_win = in_xfer && !write_q && (cyc + CYC_W'(2) >= cl)
                       && (cyc + CYC_W'(2) < cl + bl);
    assign rcapture  = in_xfer && !write_q && (cyc >= cl);

endmodule

// File: rtl/sdram_seq_pins.sv
// Device pin drive: holds the request fields and encodes commands,
// address, byte mask and write data. Assumes COL_W <= AP_BIT < ADDR_W.
module sdram_seq_pins
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8,
    parameter int DQ_W   = 16,
    parameter int AP_BIT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0]   req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic [DQ_W/8-1:0]   req_rmask,
    input  cmd_e                cmd,
    input  logic                auto_q,
    input  logic                wbeat,
    input  logic                rmask_win,
    input  logic [DQ_W-1:0]     wr_data,
    input  logic [DQ_W/8-1:0]   wr_mask,
    output logic [DQ_W/8-1:0]   rmask_q,
    output logic                wr_take,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [DQ_W/8-1:0]   sd_dqm,
    output logic [DQ_W-1:0]     sd_dq_out,
    output logic                sd_dq_oe
);
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] row_q;
    logic [COL_W-1:0]  col_q;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            rmask_q <= '0;
        end else if (accept) begin
            bank_q  <= req_bank;
            row_q   <= req_row;
            col_q   <= req_col;
            rmask_q <= req_rmask;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins(cmd);
    assign sd_ba = bank_q;

    // Address bus content per command.
    always_comb begin
        sd_addr = '0;
        case (cmd)
            CMD_ACT: sd_addr = row_q;
            CMD_READ, CMD_WRITE: begin
                sd_addr[COL_W-1:0] = col_q;
                sd_addr[AP_BIT]    = auto_q;
            end
            default: sd_addr = '0;
        endcase
    end

    assign sd_dqm    = wbeat ? wr_mask : (rmask_win ? rmask_q : '0);
    assign sd_dq_oe  = wbeat;
    assign sd_dq_out = wr_data;
    assign wr_take   = wbeat;

endmodule

// File: rtl/sdram_seq_rdcap.sv
// Read return stage: registers each word taken from the bus and
// clears the bytes the read mask covers. Assumes DQ_W is a multiple of 8.
module sdram_seq_rdcap #(
    parameter int DQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rcapture,
    input  logic [DQ_W/8-1:0] rmask_q,
    input  logic [DQ_W-1:0]   sd_dq_in,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data
);
    localparam int LANES = DQ_W / 8;
    logic [DQ_W-1:0] keep;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign keep[8*b +: 8] = {8{!rmask_q[b]}};
    end

    // Capture one word per data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rcapture;
            if (rcapture) rd_data <= sd_dq_in & keep;
        end
    end

endmodule

// File: rtl/sdram_seq.sv
// Top of the SDRAM access sequencer: one burst per request, row opened
// and closed around it. Assumes config inputs are stable while busy.
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8,
    parameter int DQ_W   = 16,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cl3,
    input  logic [1:0]          cfg_bl,
    input  logic [CNT_W-1:0]    cfg_trcd,
    input  logic [CNT_W-1:0]    cfg_twr,
    input  logic [CNT_W-1:0]    cfg_trp,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_auto,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0]   req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic [DQ_W/8-1:0]   req_rmask,
    output logic                wr_take,
    input  logic [DQ_W-1:0]     wr_data,
    input  logic [DQ_W/8-1:0]   wr_mask,
    output logic                rd_valid,
    output logic [DQ_W-1:0]     rd_data,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [DQ_W/8-1:0]   sd_dqm,
    output logic [DQ_W-1:0]     sd_dq_out,
    output logic                sd_dq_oe,
    input  logic [DQ_W-1:0]     sd_dq_in
);
    localparam int CYC_W  = 4;
    localparam int AP_BIT = 10;

    cmd_e              cmd;
    logic              accept;
    logic              auto_q;
    logic              wbeat;
    logic              rmask_win;
    logic              rcapture;
    logic [DQ_W/8-1:0] rmask_q;

    sdram_seq_ctrl #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl),
        .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_write(req_write), .req_auto(req_auto),
        .req_ready(req_ready), .accept(accept), .cmd(cmd), .auto_q(auto_q),
        .wbeat(wbeat), .rmask_win(rmask_win), .rcapture(rcapture)
    );

    sdram_seq_pins #(
        .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W),
        .DQ_W(DQ_W), .AP_BIT(AP_BIT)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_rmask(req_rmask), .cmd(cmd), .auto_q(auto_q),
        .wbeat(wbeat), .rmask_win(rmask_win),
        .wr_data(wr_data), .wr_mask(wr_mask), .rmask_q(rmask_q),
        .wr_take(wr_take), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe)
    );

    sdram_seq_rdcap #(.DQ_W(DQ_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rcapture(rcapture), .rmask_q(rmask_q),
        .sd_dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: rtl/sdram_seq_chk.sv
// Protocol checker for the sequencer, observing its ports only.
// Assumes the top is built with the address bit 10 auto-close select.
module sdram_seq_chk #(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int DQ_W   = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_trcd,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_take,
    input logic [DQ_W/8-1:0] wr_mask,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [DQ_W/8-1:0] sd_dqm,
    input logic              sd_dq_oe
);
    logic [3:0]       pins;
    logic             is_nop, is_act, is_rd, is_wr, is_pre;
    logic [CNT_W-1:0] since_act;

    assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_act = (pins == 4'b0011);
    assign is_rd  = (pins == 4'b0101);
    assign is_wr  = (pins == 4'b0100);
    assign is_pre = (pins == 4'b0010);

    // Saturating count of cycles since the last Activate.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_act <= '0;
        else if (is_act)           since_act <= CNT_W'(1);
        else if (since_act != '1)  since_act <= since_act + CNT_W'(1);
    end

    AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready) |-> is_act); // R1
    AST_ACT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> $past(req_valid && req_ready)); // R1
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> since_act == cfg_trcd); // R2
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (sd_dq_oe && wr_take)); // R3
    AST_WMASK_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> sd_dqm == wr_mask); // R4
    AST_PRE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> !sd_addr[10]); // R7
    AST_PRE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> !req_ready); // R9
    AST_READ_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> !sd_addr[10]); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (is_nop && !sd_dq_oe)); // R11

endmodule

bind sdram_seq sdram_seq_chk #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_trcd(cfg_trcd),
    .req_valid(req_valid), .req_ready(req_ready),
    .wr_take(wr_take), .wr_mask(wr_mask),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_oe(sd_dq_oe)
);

// File: tb/sim_sdram_seq.sv
// Bench: device model plus per-cycle expected pin and data checks.
module sim_sdram_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DQ_W = 16;
    localparam int ML   = DQ_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cl3 = 1'b0;
    logic [1:0] cfg_bl = 2'b00;
    logic [3:0] cfg_trcd = 4'd2, cfg_twr = 4'd2, cfg_trp = 4'd2;
    logic req_valid = 1'b0, req_write = 1'b0, req_auto = 1'b0;
    logic [1:0] req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic [ML-1:0] req_rmask = '0;
    logic [DQ_W-1:0] wr_data = '0;
    logic [ML-1:0] wr_mask = '0;
    logic [DQ_W-1:0] sd_dq_in = '0;
    logic req_ready, wr_take, rd_valid;
    logic [DQ_W-1:0] rd_data, sd_dq_out;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba;
    logic [11:0] sd_addr;
    logic [ML-1:0] sd_dqm;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl),
        .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_auto(req_auto), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_rmask(req_rmask), .wr_take(wr_take),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_valid(rd_valid),
        .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    function automatic int blen(input logic [1:0] c);
        return (c == 2'b00) ? 2 : (c == 2'b01) ? 4 : 8;
    endfunction

    function automatic logic [7:0] bcol(input logic [7:0] c, input int k, input int bl);
        logic [7:0] m;
        m = 8'(bl - 1);
        return (c & ~m) | ((c + 8'(k)) & m);
    endfunction

    function automatic int idx(input logic [1:0] b, input logic [1:0] r, input logic [7:0] c);
        return int'({b, r, c});
    endfunction

    function automatic logic [DQ_W-1:0] lanes(input logic [ML-1:0] m);
        logic [DQ_W-1:0] v;
        for (int b = 0; b < ML; b++) v[8*b +: 8] = {8{m[b]}};
        return v;
    endfunction

    function automatic logic [DQ_W-1:0] seedval(input int i);
        return DQ_W'(i * 40503) ^ 16'h5A5A;
    endfunction

    // Device model and bench shadow.
    logic [DQ_W-1:0] mem [0:4095];
    logic [DQ_W-1:0] shadow [0:4095];
    logic [1:0] orow [0:3];
    bit pv [0:15];
    int pa [0:15];
    int mcyc = 0;
    logic [ML-1:0] dqm_prev = '0;
    bit wact = 1'b0;
    logic [1:0] wba;
    logic [7:0] wcol;
    int wk, wbl;

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = seedval(i);
            shadow[i] = seedval(i);
        end
        for (int i = 0; i < 16; i++) pv[i] = 1'b0;
        for (int i = 0; i < 4; i++) orow[i] = '0;
    end

    always @(posedge clk) begin
        logic [3:0] p;
        int s, cl, bl;
        p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        cl = cfg_cl3 ? 3 : 2;
        bl = blen(cfg_bl);
        if (rst_n) begin
            if (p == 4'b0011) orow[sd_ba] = sd_addr[1:0];
            if (p == 4'b0101) begin
                for (int k = 0; k < bl; k++) begin
                    s = (mcyc + cl + k) % 16;
                    pv[s] = 1'b1;
                    pa[s] = idx(sd_ba, orow[sd_ba], bcol(sd_addr[7:0], k, bl));
                end
            end
            if (p == 4'b0100) begin
                wact = 1'b1; wba = sd_ba; wcol = sd_addr[7:0]; wk = 0; wbl = bl;
            end
            if (sd_dq_oe && wact) begin
                s = idx(wba, orow[wba], bcol(wcol, wk, wbl));
                mem[s] = (mem[s] & lanes(sd_dqm)) | (sd_dq_out & ~lanes(sd_dqm));
                wk++;
                if (wk == wbl) wact = 1'b0;
            end
        end
        s = (mcyc + 1) % 16;
        if (pv[s]) begin
            sd_dq_in <= mem[pa[s]] & ~lanes(dqm_prev);
            pv[s] = 1'b0;
        end else begin
            sd_dq_in <= 16'hDEAD;
        end
        dqm_prev = sd_dqm;
        mcyc++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [DQ_W-1:0] bd [0:7];
    logic [ML-1:0] bm [0:7];

    // One access, checked cycle by cycle from the accept edge.
    task automatic access(input bit wr, input logic [1:0] bank, input logic [11:0] row,
                          input logic [7:0] col, input bit au, input logic [ML-1:0] rm);
        int cl, bl, C, L, P, R, wk2, k;
        logic [3:0] ep, p;
        logic [DQ_W-1:0] ed;
        string tag;
        cl = cfg_cl3 ? 3 : 2;
        bl = blen(cfg_bl);
        C = 1 + int'(cfg_trcd);
        L = C + bl - 1;
        P = wr ? (L + int'(cfg_twr)) : (C + cl + bl);
        R = P + int'(cfg_trp);
        wk2 = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
        req_write = wr; req_bank = bank; req_row = row; req_col = col;
        req_auto = au; req_rmask = rm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 1; i <= R; i++) begin
            if (wr_take && wk2 < 8) begin
                wr_data = bd[wk2]; wr_mask = bm[wk2]; wk2++;
            end
            #1;
            p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            ep = 4'b0111; tag = "R11";
            if (i == 1) begin ep = 4'b0011; tag = "R1"; end
            else if (i == C) begin ep = wr ? 4'b0100 : 4'b0101; tag = "R2"; end
            else if (i == P && !(wr && au)) begin ep = 4'b0010; tag = "R7"; end
            else if (i == P) tag = "R8";
            check(p == ep, tag, "command pins", p, ep);
            if (i == 1) begin
                check(sd_ba == bank && sd_addr == row, "R1", "activate bank/row",
                      {sd_ba, sd_addr}, {bank, row});
            end
            if (i == C) begin
                check(sd_addr[7:0] == col, "R2", "column", sd_addr[7:0], col);
                check(sd_addr[10] == (wr && au), wr ? "R8" : "R10", "auto-close bit",
                      sd_addr[10], wr && au);
            end
            if (i == P && !(wr && au)) begin
                check(sd_addr[10] == 1'b0 && sd_ba == bank, "R7", "precharge bank/bit10",
                      {sd_ba, sd_addr[10]}, {bank, 1'b0});
            end
            if (wr) begin
                if (i >= C && i <= L) begin
                    k = i - C;
                    check(sd_dq_oe && wr_take, "R3", "write beat enables",
                          {sd_dq_oe, wr_take}, 2'b11);
                    check(sd_dq_out == bd[k], "R3", "write data", sd_dq_out, bd[k]);
                    check(sd_dqm == bm[k], "R4", "write mask same cycle", sd_dqm, bm[k]);
                end else begin
                    check(!sd_dq_oe && !wr_take && sd_dqm == '0, "R3", "idle data pins",
                          {sd_dq_oe, wr_take, sd_dqm}, 0);
                end
            end else begin
                check(!sd_dq_oe, "R3", "no drive on read", sd_dq_oe, 0);
                if (i >= C + cl - 2 && i <= C + cl + bl - 3)
                    check(sd_dqm == rm, "R6", "read mask lead", sd_dqm, rm);
                else
                    check(sd_dqm == '0, "R6", "read mask off", sd_dqm, 0);
                if (i >= C + cl + 1 && i <= C + cl + bl) begin
                    k = i - C - cl - 1;
                    ed = shadow[idx(bank, row[1:0], bcol(col, k, bl))] & ~lanes(rm);
                    check(rd_valid == 1'b1, "R5", "read valid", rd_valid, 1);
                    check(rd_data == ed, "R5", "read data", rd_data, ed);
                end else begin
                    check(rd_valid == 1'b0, "R5", "read valid low", rd_valid, 0);
                end
            end
            check(req_ready == (i == R), (wr && au) ? "R8" : "R9", "ready timing",
                  req_ready, i == R);
            if (i < R) @(negedge clk);
        end
        if (wr) begin
            for (int q = 0; q < bl; q++) begin
                k = idx(bank, row[1:0], bcol(col, q, bl));
                shadow[k] = (shadow[k] & lanes(bm[q])) | (bd[q] & ~lanes(bm[q]));
            end
        end
    endtask

    task automatic set_cfg(input bit c3, input logic [1:0] b, input int rcd,
                           input int wrr, input int rp);
        cfg_cl3 = c3; cfg_bl = b;
        cfg_trcd = 4'(rcd); cfg_twr = 4'(wrr); cfg_trp = 4'(rp);
    endtask

    task automatic fill_beats(input logic [ML-1:0] fixed_mask, input bit use_fixed);
        for (int q = 0; q < 8; q++) begin
            bd[q] = DQ_W'($urandom);
            bm[q] = use_fixed ? fixed_mask : ML'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R11", "reset NOP",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        check(req_ready && !sd_dq_oe && sd_dqm == '0 && !rd_valid, "R11", "reset outputs",
              {req_ready, sd_dq_oe, sd_dqm, rd_valid}, 5'b10000);
        rst_n = 1'b1;
        // Directed: mixed write masks, then read back unmasked.
        set_cfg(1'b0, 2'b01, 2, 2, 2);
        fill_beats('0, 1'b0);
        bm[0] = 2'b11; bm[1] = 2'b01; bm[2] = 2'b10; bm[3] = 2'b00;
        access(1'b1, 2'd1, 12'h002, 8'h10, 1'b0, '0);
        access(1'b0, 2'd1, 12'h002, 8'h10, 1'b0, '0);
        // Directed: CL3, 8-word burst, unaligned, upper lane masked.
        set_cfg(1'b1, 2'b10, 3, 3, 2);
        access(1'b0, 2'd1, 12'h002, 8'h13, 1'b0, 2'b10);
        // Directed: auto-close write with long recovery.
        set_cfg(1'b1, 2'b11, 5, 4, 3);
        fill_beats(2'b00, 1'b1);
        access(1'b1, 2'd3, 12'h801, 8'h20, 1'b1, '0);
        // Directed: auto flag on a read is ignored.
        set_cfg(1'b0, 2'b00, 2, 2, 2);
        access(1'b0, 2'd3, 12'h801, 8'h21, 1'b1, 2'b01);
        // Random mix.
        for (int n = 0; n < 70; n++) begin
            set_cfg(1'($urandom), 2'($urandom), 2 + $urandom % 4,
                    2 + $urandom % 4, 2 + $urandom % 4);
            fill_beats('0, 1'b0);
            access(1'($urandom), 2'($urandom), 12'($urandom), 8'($urandom),
                   1'($urandom), ML'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule